// File: doc/BRIEF.md
# Byte-Serial Memory Read-Out Multiplexer

This block sends memory read data out through a single 8-bit port. Two read sources feed it: a 32-bit word from the wide memory and a 10-bit word from the narrow memory. A 2-bit module select chooses which source is used. A byte select then chooses which 8-bit lane of that word is presented. An external controller can therefore walk through a whole read word one byte at a time, stepping the byte select while read enable is held high.

The narrow word is first zero-extended to the width of the wide word, so both sources share one lane multiplexer. The chosen byte is captured in an output register on the rising clock edge, and only while read enable is high. Otherwise the register keeps its value. A synchronous active-high reset clears the register.

Top module: `byte_readout_mux`

## Requirements
- R1: When `rst` is high at a rising edge, `byte_out` reads 0x00 after that edge, whatever the other inputs are.
- R2: When `rd_en` is low at a rising edge (and `rst` is low), `byte_out` keeps its previous value.
- R3: With `rd_en` high and `mod_sel` = 0 (wide source), `byte_out` after the edge equals bits [8k+7:8k] of `wide_word`, where k is the value of `byte_sel` (k = 0 selects the least significant byte).
- R4: With `rd_en` high and `mod_sel` = 1 (narrow source), `byte_sel` = 0 gives `narrow_word[7:0]`, and `byte_sel` = 1 gives `narrow_word[9:8]` in bits [1:0] with bits [7:2] zero.
- R5: With `rd_en` high, `mod_sel` = 1 and `byte_sel` = 2 or 3, `byte_out` reads 0x00.
- R6: With `rd_en` high and `mod_sel` = 2 or 3 (no source assigned), `byte_out` reads 0x00 whatever the data inputs hold.
- R7: `byte_out` changes only at rising edges. Input changes between edges have no effect on it until the next edge, so the output has exactly one cycle of latency.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_en | input | 1 | Read enable; the output register loads only while this is high |
| mod_sel | input | 2 | Source select: 0 wide, 1 narrow, 2/3 none |
| byte_sel | input | 2 | Byte lane index, 0 is least significant |
| wide_word | input | 32 | Read word of the wide memory |
| narrow_word | input | 10 | Read word of the narrow memory |
| byte_out | output | 8 | Registered read byte |

## Verification
The bench builds the block with its default parameters: a 32-bit wide source, a 10-bit narrow source, 8-bit lanes and a 2-bit byte select. With these values all four byte-select codes and all four module-select codes can be reached, including the two unassigned ones. The narrow source straddles the first lane boundary, so the partly padded lane 1 and the fully padded lanes 2 and 3 are all exercised. Random patterns with read enable toggling are mixed with directed cases, including data inputs changed between edges.

// File: rtl/brm_pkg.sv
package brm_pkg;
  // Module-select codes; the decode order is fixed by the block's contract
  localparam logic [1:0] SRC_WIDE   = 2'd0;
  localparam logic [1:0] SRC_NARROW = 2'd1;
endpackage

// File: rtl/brm_zero_ext.sv
module brm_zero_ext #(
  parameter int IN_W  = 10,
  parameter int OUT_W = 32
) (
  input  logic [IN_W-1:0]  din,
  output logic [OUT_W-1:0] dout
);
  generate
    if (OUT_W > IN_W) begin : g_pad
      localparam int PAD_W = OUT_W - IN_W;
      assign dout = {{PAD_W{1'b0}}, din};
    end else if (OUT_W == IN_W) begin : g_same
      assign dout = din;
    end else begin : g_cut
      assign dout = din[OUT_W-1:0];
    end
  endgenerate
endmodule

// File: rtl/brm_src_sel.sv
module brm_src_sel #(
  parameter int WORD_W = 32,
  parameter int SEL_W  = 2
) (
  input  logic [SEL_W-1:0]  mod_sel,
  input  logic [WORD_W-1:0] wide_w,
  input  logic [WORD_W-1:0] narrow_w,
  output logic [WORD_W-1:0] word
);
  import brm_pkg::*;

  always_comb begin
    word = '0;
    if (mod_sel == SEL_W'(SRC_WIDE))        word = wide_w;
    else if (mod_sel == SEL_W'(SRC_NARROW)) word = narrow_w;
  end
endmodule

// File: rtl/brm_lane_mux.sv
module brm_lane_mux #(
  parameter int WORD_W = 32,
  parameter int LANE_W = 8,
  parameter int IDX_W  = 2
) (
  input  logic [WORD_W-1:0] word,
  input  logic [IDX_W-1:0]  idx,
  output logic [LANE_W-1:0] lane
);
  localparam int LANES = WORD_W / LANE_W;
  localparam int SLOTS = 1 << IDX_W;

  logic [LANE_W-1:0] lanes [SLOTS];

  generate
    for (genvar g = 0; g < SLOTS; g++) begin : g_lane
      if (g < LANES) begin : g_real
        assign lanes[g] = word[g*LANE_W +: LANE_W];
      end else begin : g_empty
        assign lanes[g] = '0;
      end
    end
  endgenerate

  assign lane = lanes[idx];
endmodule

// File: rtl/brm_out_reg.sv
module brm_out_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)       q <= '0;
    else if (load) q <= d;
  end
endmodule

// File: rtl/byte_readout_mux.sv
module byte_readout_mux #(
  parameter int WIDE_W   = 32,
  parameter int NARROW_W = 10,
  parameter int BYTE_W   = 8,
  parameter int MSEL_W   = 2,
  parameter int BSEL_W   = $clog2(WIDE_W / BYTE_W)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                rd_en,
  input  logic [MSEL_W-1:0]   mod_sel,
  input  logic [BSEL_W-1:0]   byte_sel,
  input  logic [WIDE_W-1:0]   wide_word,
  input  logic [NARROW_W-1:0] narrow_word,
  output logic [BYTE_W-1:0]   byte_out
);
  logic [WIDE_W-1:0] narrow_ext;
  logic [WIDE_W-1:0] src_word;
  logic [BYTE_W-1:0] lane_byte;

  brm_zero_ext #(.IN_W(NARROW_W), .OUT_W(WIDE_W)) u_ext (
    .din (narrow_word),
    .dout(narrow_ext)
  );

  brm_src_sel #(.WORD_W(WIDE_W), .SEL_W(MSEL_W)) u_src (
    .mod_sel (mod_sel),
    .wide_w  (wide_word),
    .narrow_w(narrow_ext),
    .word    (src_word)
  );

  brm_lane_mux #(.WORD_W(WIDE_W), .LANE_W(BYTE_W), .IDX_W(BSEL_W)) u_lane (
    .word(src_word),
    .idx (byte_sel),
    .lane(lane_byte)
  );

  brm_out_reg #(.W(BYTE_W)) u_oreg (
    .clk (clk),
    .rst (rst),
    .load(rd_en),
    .d   (lane_byte),
    .q   (byte_out)
  );
endmodule

// File: rtl/brm_chk.sv
module brm_chk #(
  parameter int WIDE_W   = 32,
  parameter int NARROW_W = 10,
  parameter int BYTE_W   = 8,
  parameter int MSEL_W   = 2,
  parameter int BSEL_W   = 2
) (
  input logic                clk,
  input logic                rst,
  input logic                rd_en,
  input logic [MSEL_W-1:0]   mod_sel,
  input logic [BSEL_W-1:0]   byte_sel,
  input logic [WIDE_W-1:0]   wide_word,
  input logic [NARROW_W-1:0] narrow_word,
  input logic [BYTE_W-1:0]   byte_out
);
  // R1
  rst_clear_chk: assert property (@(posedge clk) rst |=> byte_out == '0);

  // R2
  hold_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(byte_out));

  // R3
  wide_lane_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en && mod_sel == MSEL_W'(0)) |=>
      byte_out == BYTE_W'($past(wide_word) >> ($past(byte_sel) * BYTE_W)));

  // R4
  narrow_low_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en && mod_sel == MSEL_W'(1) && byte_sel == BSEL_W'(0)) |=>
      byte_out == BYTE_W'($past(narrow_word)));

  // R5
  narrow_pad_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en && mod_sel == MSEL_W'(1) && byte_sel[BSEL_W-1]) |=> byte_out == '0);

  // R6
  no_source_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en && mod_sel[MSEL_W-1]) |=> byte_out == '0);
endmodule

bind byte_readout_mux brm_chk #(
  .WIDE_W(WIDE_W), .NARROW_W(NARROW_W), .BYTE_W(BYTE_W),
  .MSEL_W(MSEL_W), .BSEL_W(BSEL_W)
) u_chk (
  .clk(clk), .rst(rst), .rd_en(rd_en), .mod_sel(mod_sel),
  .byte_sel(byte_sel), .wide_word(wide_word),
  .narrow_word(narrow_word), .byte_out(byte_out)
);

// File: tb/tb_byte_readout_mux.sv
module tb_byte_readout_mux;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        rd_en = 1'b0;
  logic [1:0]  mod_sel = '0;
  logic [1:0]  byte_sel = '0;
  logic [31:0] wide_word = '0;
  logic [9:0]  narrow_word = '0;
  logic [7:0]  byte_out;

  int total = 0;
  int bad = 0;
  int model = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  byte_readout_mux dut (
    .clk(clk), .rst(rst), .rd_en(rd_en), .mod_sel(mod_sel),
    .byte_sel(byte_sel), .wide_word(wide_word),
    .narrow_word(narrow_word), .byte_out(byte_out)
  );

  function automatic string tag_of(bit r, bit e, int m, int b);
    if (r) return "R1";
    if (!e) return "R2";
    if (m == 0) return "R3";
    if (m == 1) return (b < 2) ? "R4" : "R5";
    return "R6";
  endfunction

  task automatic check(string tag, int exp);
    total++;
    if (int'(byte_out) != exp) begin
      bad++;
      $display("FAIL %s: byte_out=0x%02h expected=0x%02h", tag, byte_out, exp[7:0]);
    end
  endtask

  // One cycle: apply inputs, update model at edge, optionally disturb data
  // after the edge (R7), compare at the falling edge.
  task automatic step(bit r, bit e, int m, int b, logic [31:0] w, logic [9:0] n, bit disturb);
    longint src;
    string tag;
    rst = r; rd_en = e; mod_sel = 2'(m); byte_sel = 2'(b);
    wide_word = w; narrow_word = n;
    @(posedge clk);
    if (r) model = 0;
    else if (e) begin
      if (m == 0) src = longint'(w);
      else if (m == 1) src = longint'(n);
      else src = 0;
      model = int'((src >> (8 * b)) & 255);
    end
    tag = tag_of(r, e, m, b);
    if (disturb) begin
      #1;
      wide_word = ~w; narrow_word = ~n; mod_sel = ~mod_sel; byte_sel = ~byte_sel;
      tag = "R7";
    end
    @(negedge clk);
    check(tag, model);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    bad++;
    $display("FAIL watchdog: byte_out=0x%02h expected=finish", byte_out);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    @(negedge clk);
    // R1: reset state
    step(1, 1, 0, 0, 32'hDEADBEEF, 10'h3FF, 0);
    step(1, 0, 1, 1, 32'h12345678, 10'h155, 0);
    // R3: every lane of the wide word
    for (int k = 0; k < 4; k++) step(0, 1, 0, k, 32'hA1B2C3D4, 10'h000, 0);
    // R4/R5: narrow lanes
    for (int k = 0; k < 4; k++) step(0, 1, 1, k, 32'hFFFFFFFF, 10'h3A5, 0);
    step(0, 1, 1, 1, 32'h0, 10'h2FF, 0);
    // R6: unassigned selects with all-ones data
    step(0, 1, 2, 0, 32'hFFFFFFFF, 10'h3FF, 0);
    step(0, 1, 3, 3, 32'hFFFFFFFF, 10'h3FF, 0);
    // R2: hold with changing inputs
    step(0, 1, 0, 2, 32'h00AB0000, 10'h0, 0);
    step(0, 0, 0, 0, 32'h11111111, 10'h3FF, 0);
    step(0, 0, 3, 1, 32'h22222222, 10'h001, 0);
    // R7: inputs disturbed between edges
    step(0, 1, 0, 1, 32'h00005A00, 10'h0, 1);
    step(0, 1, 1, 0, 32'h0, 10'h0C3, 1);
    // R1: reset mid-run after a non-zero byte
    step(0, 1, 0, 0, 32'h000000FF, 10'h0, 0);
    step(1, 1, 0, 0, 32'h000000FF, 10'h0, 0);
    // Random mix covering all tags
    for (int i = 0; i < 400; i++) begin
      step(($urandom % 20) == 0, ($urandom % 4) != 0, int'($urandom % 4),
           int'($urandom % 4), 32'($urandom), 10'($urandom), ($urandom % 8) == 0);
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule